// File: doc/BRIEF.md
# GPIO port with single-pin event interrupt

This block is a 16-pin general-purpose I/O port on a simple synchronous 16-bit register bus. Software sets each pin's direction and output level, reads back the sampled pin levels, and can arm one pin to raise an interrupt on a chosen edge. The port also merges an external keypad interrupt line into a shared status word. A per-source mask decides which status bits reach the single interrupt output.

Every pad input passes through a two-flop synchronizer. The synchronizer, the input register and the edge detector advance only while the module clock-enable bit is set. The pad output-enable and output-data lines come straight from the registers, so pins keep their driven state while the module clock is off. One field in the event-mode register picks the monitored pin by index, and another picks the edge polarity. The GPIO event bit clears when the status word is read. The keypad bit follows its input line and is not cleared by a read.

Top module: `gpio_evt_port`

## Requirements
- R1: After a synchronous reset, direction reads 0xFFFF (all inputs, pad_oe all 0), output data reads 0 (pad_out 0), control reads 0, event mode reads 0, mask reads 0x0003 (both sources masked) and irq is 0.
- R2: A bus write to offset 0x4 (direction, 1 = input) sets pad_oe to its bitwise inverse on the next cycle. A write to offset 0x2 sets pad_out on the next cycle. pad_out does not change without such a write, and it is driven whether the clock enable is set or clear.
- R3: With the clock enable set, a read of offset 0x0 returns the pad levels after two synchronizer stages. Read data appears on bus_rdata one cycle after the read strobe.
- R4: Control register offset 0x6 stores only bit 5, the clock enable, and its other bits read as 0. While bit 5 is clear, the input value is frozen and no GPIO event is detected.
- R5: In the event-mode register at offset 0x8, bit 0 enables detection, bits 4:1 give the monitored pin index and bit 5 selects the edge (1 rising, 0 falling). Transitions on other pins, or of the other polarity, raise no event.
- R6: A detected event sets status bit 1 at offset 0xA. A status read returns the bit and clears it. Status bits 15:2 read as 0.
- R7: When an event is detected in the same cycle as a status read, the GPIO status bit stays set. That read returns the old value.
- R8: Status bit 0 follows kpd_irq_in one cycle late and is not cleared by a read.
- R9: The mask register at offset 0xC has bit 0 for the keypad and bit 1 for the GPIO event, where 1 masks the source. irq is the OR of the status bits whose mask bit is 0.
- R10: Any write to the event-mode register discards the edge history. A level that differs from the previously monitored pin therefore raises no event until the newly selected pin actually changes.
- R11: Writes to offset 0x0 and to unmapped offsets (0xE) have no effect. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output data to the pad drivers |
| pad_oe | output | 16 | Pad output enables, 1 = drive |
| kpd_irq_in | input | 1 | External keypad interrupt level |
| irq | output | 1 | Combined masked interrupt |

## Verification
A stale or corrupt edge history, such as a previous-level flop that is not reloaded after the monitored pin changes, shows up as a spurious status bit 1. That bit appears on the first status read and, when the source is unmasked, on irq within three cycles of the event-mode write. A wrong clear priority shows up on the read after a coincident event: bit 1 reads as 0 where it should read as 1. A wrong synchronizer gate shows up as input reads that change while the enable is clear. Direction and output-data faults are visible on pad_oe and pad_out one cycle after the offending write.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int unsigned BUS_AW = 4;

  // word index = byte offset >> 1
  typedef enum logic [2:0] {
    RSEL_IN   = 3'd0,
    RSEL_OUT  = 3'd1,
    RSEL_DIR  = 3'd2,
    RSEL_CTRL = 3'd3,
    RSEL_EVT  = 3'd4,
    RSEL_STAT = 3'd5,
    RSEL_MASK = 3'd6,
    RSEL_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned CTRL_CLKEN_BIT = 5;
  localparam int unsigned EVT_ON_BIT     = 0;
  localparam int unsigned SRC_KPD        = 0;
  localparam int unsigned SRC_GPIO       = 1;
  localparam int unsigned NSRC           = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else if (en) begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned NPINS = 16,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             arm,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             rise_sel,
  input  logic             restart,
  input  logic [NPINS-1:0] pins,
  output logic             hit
);

  logic cur_lvl;
  logic prev_q;
  logic hist_ok_q;
  logic rise_seen;
  logic fall_seen;

  assign cur_lvl = pins[sel_idx];

  // history is dropped on every mode write and reloaded on the next enabled cycle
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      prev_q    <= 1'b0;
      hist_ok_q <= 1'b0;
    end else if (en) begin
      prev_q    <= cur_lvl;
      hist_ok_q <= 1'b1;
    end
  end

  assign rise_seen = cur_lvl & ~prev_q;
  assign fall_seen = ~cur_lvl & prev_q;
  assign hit = en & arm & hist_ok_q & ~restart & (rise_sel ? rise_seen : fall_seen);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IDX_W = $clog2(NPINS),
  localparam int unsigned EVT_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  in_val,
  input  logic              kpd_lvl,
  input  logic              gpio_hit,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  out_o,
  output logic              clk_en_o,
  output logic              evt_on_o,
  output logic [IDX_W-1:0]  evt_idx_o,
  output logic              evt_rise_o,
  output logic              evt_wr_o,
  output logic              irq_o
);

  reg_sel_e             rsel;
  logic                 wr_any;
  logic                 rd_any;
  logic [NPINS-1:0]     dir_q;
  logic [NPINS-1:0]     out_q;
  logic                 clk_en_q;
  logic [EVT_W-1:0]     evt_q;
  logic                 kpd_q;
  logic                 gpio_st_q;
  logic [NSRC-1:0]      mask_q;
  logic [NSRC-1:0]      stat_vec;
  logic [NSRC-1:0]      gated;
  logic [DW-1:0]        rd_mux;
  logic [DW-1:0]        rdata_q;

  assign rsel   = reg_sel_e'(bus_addr[BUS_AW-1:1]);
  assign wr_any = bus_sel & bus_we;
  assign rd_any = bus_sel & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '1;
      out_q    <= '0;
      clk_en_q <= 1'b0;
      evt_q    <= '0;
      mask_q   <= '1;
    end else if (wr_any) begin
      case (rsel)
        RSEL_OUT:  out_q    <= bus_wdata[NPINS-1:0];
        RSEL_DIR:  dir_q    <= bus_wdata[NPINS-1:0];
        RSEL_CTRL: clk_en_q <= bus_wdata[CTRL_CLKEN_BIT];
        RSEL_EVT:  evt_q    <= bus_wdata[EVT_W-1:0];
        RSEL_MASK: mask_q   <= bus_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  // keypad level is only retimed, never cleared
  always_ff @(posedge clk) begin
    kpd_q <= kpd_lvl;
  end

  // set has priority over the clear-on-read
  always_ff @(posedge clk) begin
    if (rst) begin
      gpio_st_q <= 1'b0;
    end else if (gpio_hit) begin
      gpio_st_q <= 1'b1;
    end else if (rd_any && rsel == RSEL_STAT) begin
      gpio_st_q <= 1'b0;
    end
  end

  always_comb begin
    stat_vec           = '0;
    stat_vec[SRC_KPD]  = kpd_q;
    stat_vec[SRC_GPIO] = gpio_st_q;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src_gate
    assign gated[s] = stat_vec[s] & ~mask_q[s];
  end

  assign irq_o = |gated;

  always_comb begin
    rd_mux = '0;
    case (rsel)
      RSEL_IN:   rd_mux[NPINS-1:0]     = in_val;
      RSEL_OUT:  rd_mux[NPINS-1:0]     = out_q;
      RSEL_DIR:  rd_mux[NPINS-1:0]     = dir_q;
      RSEL_CTRL: rd_mux[CTRL_CLKEN_BIT] = clk_en_q;
      RSEL_EVT:  rd_mux[EVT_W-1:0]     = evt_q;
      RSEL_STAT: rd_mux[NSRC-1:0]      = stat_vec;
      RSEL_MASK: rd_mux[NSRC-1:0]      = mask_q;
      default:   rd_mux                = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign dir_o      = dir_q;
  assign out_o      = out_q;
  assign clk_en_o   = clk_en_q;
  assign evt_on_o   = evt_q[EVT_ON_BIT];
  assign evt_idx_o  = evt_q[IDX_W:1];
  assign evt_rise_o = evt_q[IDX_W+1];
  assign evt_wr_o   = wr_any && (rsel == RSEL_EVT);

endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic              kpd_irq_in,
  output logic              irq
);

  logic [NPINS-1:0] sync_val;
  logic [NPINS-1:0] dir_w;
  logic [NPINS-1:0] out_w;
  logic             clk_en_w;
  logic             evt_on_w;
  logic [IDX_W-1:0] evt_idx_w;
  logic             evt_rise_w;
  logic             evt_wr_w;
  logic             hit_w;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .en  (clk_en_w),
    .d   (pad_in),
    .q   (sync_val)
  );

  gpio_edge_det #(.NPINS(NPINS)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en_w),
    .arm      (evt_on_w),
    .sel_idx  (evt_idx_w),
    .rise_sel (evt_rise_w),
    .restart  (evt_wr_w),
    .pins     (sync_val),
    .hit      (hit_w)
  );

  gpio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .in_val     (sync_val),
    .kpd_lvl    (kpd_irq_in),
    .gpio_hit   (hit_w),
    .dir_o      (dir_w),
    .out_o      (out_w),
    .clk_en_o   (clk_en_w),
    .evt_on_o   (evt_on_w),
    .evt_idx_o  (evt_idx_w),
    .evt_rise_o (evt_rise_w),
    .evt_wr_o   (evt_wr_w),
    .irq_o      (irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pad_oe[p]  = ~dir_w[p];
    assign pad_out[p] = out_w[p];
  end

endmodule

// File: rtl/gpio_evt_port_chk.sv
module gpio_evt_port_chk #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             kpd_irq_in
);

  logic wr_dir, wr_out, rd_stat, rd_ctrl, rd_none;
  assign wr_dir  = bus_sel & bus_we & (bus_addr[3:1] == 3'd2);
  assign wr_out  = bus_sel & bus_we & (bus_addr[3:1] == 3'd1);
  assign rd_ctrl = bus_sel & ~bus_we & (bus_addr[3:1] == 3'd3);
  assign rd_stat = bus_sel & ~bus_we & (bus_addr[3:1] == 3'd5);
  assign rd_none = bus_sel & ~bus_we & (bus_addr[3:1] == 3'd7);

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pad_oe == ~$past(bus_wdata[NPINS-1:0]));

  p_out_wr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> pad_out == $past(bus_wdata[NPINS-1:0]));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_out |=> $stable(pad_out));

  p_ctrl_bits_r4: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> (bus_rdata & ~(DW'(1) << 5)) == '0);

  p_stat_upper_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> bus_rdata[DW-1:2] == '0);

  p_kpd_follow_r8: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> bus_rdata[0] == $past(kpd_irq_in, 2));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    rd_none |=> bus_rdata == '0);

endmodule

bind gpio_evt_port gpio_evt_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .kpd_irq_in (kpd_irq_in)
);

// File: tb/tb_gpio_evt_port.sv
module tb_gpio_evt_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out;
  logic [15:0] pad_oe;
  logic        kpd_irq_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  gpio_evt_port dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .kpd_irq_in(kpd_irq_in), .irq(irq)
  );

  // {req number, byte offset, write data, expected readback}
  localparam logic [39:0] VEC [7] = '{
    {4'd2,  4'h2, 16'hA5C3, 16'hA5C3},
    {4'd2,  4'h2, 16'h0000, 16'h0000},
    {4'd2,  4'h4, 16'h0F0F, 16'h0F0F},
    {4'd4,  4'h6, 16'hFFFF, 16'h0020},
    {4'd5,  4'h8, 16'hFFFF, 16'h003F},
    {4'd9,  4'hC, 16'hFFFF, 16'h0003},
    {4'd11, 4'hE, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 16'h0000);
    chk("R1 pad_out", pad_out, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rd(4'h4, v); chk("R1 dir", v, 16'hFFFF);
    rd(4'hC, v); chk("R1 mask", v, 16'h0003);
    rd(4'h6, v); chk("R1 ctrl", v, 16'h0000);
    rd(4'h8, v); chk("R1 evt", v, 16'h0000);

    // register vector table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      if (VEC[i][35:32] == 4'h4) chk($sformatf("R%0d vec%0d oe", VEC[i][39:36], i), pad_oe, ~VEC[i][31:16]);
      if (VEC[i][35:32] == 4'h2) chk($sformatf("R%0d vec%0d out", VEC[i][39:36], i), pad_out, VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk($sformatf("R%0d vec%0d rd", VEC[i][39:36], i), v, VEC[i][15:0]);
    end

    wr(4'h8, 16'h0000); wr(4'h6, 16'h0020); wr(4'hC, 16'h0003);

    // R3 synchronized input
    pad_in = 16'h1234; idle(4);
    rd(4'h0, v); chk("R3 input", v, 16'h1234);

    // R11 write to input ignored
    wr(4'h0, 16'hFFFF);
    rd(4'h0, v); chk("R11 input wr ignored", v, 16'h1234);

    // R2 pad drive while clock disabled
    wr(4'h6, 16'h0000);
    wr(4'h2, 16'h5A5A); chk("R2 out clk off", pad_out, 16'h5A5A);
    wr(4'h4, 16'h00FF); chk("R2 oe", pad_oe, 16'hFF00);

    // R4 frozen input and no events while disabled
    wr(4'h8, 16'h0021);
    pad_in = 16'hABCD; idle(4);
    rd(4'h0, v); chk("R4 input frozen", v, 16'h1234);
    rd(4'hA, v); chk("R4 no event", v, 16'h0000);
    pad_in = 16'h1234; idle(2);
    wr(4'h6, 16'h0020); idle(4);
    rd(4'hA, v); chk("R4 reenable quiet", v, 16'h0000);

    // R5 pin 7 rising
    wr(4'h8, 16'h002F); idle(2);
    pad_in = 16'h1274; idle(4);
    rd(4'hA, v); chk("R5 other pin", v, 16'h0000);
    pad_in = 16'h12F4; idle(4);
    rd(4'hA, v); chk("R6 event set", v, 16'h0002);
    rd(4'hA, v); chk("R6 cleared by read", v, 16'h0000);

    // R5 falling select
    wr(4'h8, 16'h000F); idle(2);
    pad_in = 16'h1274; idle(4);
    rd(4'hA, v); chk("R5 falling", v, 16'h0002);
    pad_in = 16'h12F4; idle(4);
    rd(4'hA, v); chk("R5 rising ignored", v, 16'h0000);

    // R9 masking
    wr(4'hC, 16'h0001);
    pad_in = 16'h1274; idle(4);
    chk("R9 irq unmasked", {15'd0, irq}, 16'h0001);
    wr(4'hC, 16'h0003); chk("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(4'hC, 16'h0001); chk("R9 irq unmask again", {15'd0, irq}, 16'h0001);
    rd(4'hA, v); chk("R9 status", v, 16'h0002);
    chk("R9 irq after clear", {15'd0, irq}, 16'h0000);

    // R8 keypad level
    kpd_irq_in = 1'b1; idle(2);
    rd(4'hA, v); chk("R8 kpd set", v, 16'h0001);
    rd(4'hA, v); chk("R8 kpd not cleared", v, 16'h0001);
    chk("R8 kpd masked irq", {15'd0, irq}, 16'h0000);
    wr(4'hC, 16'h0002); chk("R8 kpd irq", {15'd0, irq}, 16'h0001);
    kpd_irq_in = 1'b0; idle(1);
    chk("R8 kpd irq drop", {15'd0, irq}, 16'h0000);
    wr(4'hC, 16'h0003);

    // R7 event coincident with status read
    wr(4'h8, 16'h002F); idle(2);
    rd(4'hA, v);
    pad_in = 16'h12F4;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'hA;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    chk("R7 coincident read old", bus_rdata, 16'h0000);
    rd(4'hA, v); chk("R7 event kept", v, 16'h0002);
    rd(4'hA, v); chk("R7 then cleared", v, 16'h0000);

    // R10 history reset on mode write (pin 8 low, pin 7 high)
    wr(4'h8, 16'h0031); idle(3);
    wr(4'h8, 16'h002F); idle(4);
    rd(4'hA, v); chk("R10 no stale event", v, 16'h0000);

    // R1 reset again after activity
    wr(4'h4, 16'h0000); wr(4'h2, 16'hFFFF); wr(4'hC, 16'h0000);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk("R1 oe after reset", pad_oe, 16'h0000);
    chk("R1 out after reset", pad_out, 16'h0000);
    rd(4'hC, v); chk("R1 mask after reset", v, 16'h0003);

    finish_run();
  end

endmodule